// File: doc/BRIEF.md
# Protected Segment Firewall

This block sits beside the system bus and the instruction-fetch path and guards three protected memory regions: a code region, a non-volatile data region and a volatile data region. Each region is defined by a start and a length. The code and non-volatile regions use 256-byte units, and the volatile region uses 64-byte units. Software loads the region settings and pulses an arm input. From then on the settings are frozen until the next reset.

Once the block is armed, it tracks whether protected code is currently running (open) or not (closed). The only way to open it is to fetch an instruction from the entry point, which is a fixed offset into the code region. While the block is closed, touching a protected region is a violation. Two flags on the volatile region relax this: one lets unprotected code share the region, and the other permits execution from it. Leaving the protected code closes the block again. Every violation raises a one-cycle reset request to the system reset logic and records which region was hit first.

Top module: `fw_guard`

## Requirements
- R1: While reset is held and just after it, fw_armed, fw_open and rst_req are 0 and viol_seg is 0.
- R2: Before arming, no access raises rst_req. A cfg_arm pulse captures all cfg_* inputs, and fw_armed reads 1 from the next cycle. fw_open can only be 1 while armed.
- R3: Once the block is armed, later cfg_arm pulses and changes on the cfg_* inputs have no effect until reset. The region checks keep using the settings captured first.
- R4: An address is inside a region when it lies in the byte range from start×G up to start×G + length×G − 1. G is 256 for the code and non-volatile regions and 64 for the volatile region. A length of 0 gives an empty region.
- R5: While the block is closed, a valid fetch at byte address code_start×256 + 4 (the entry point) opens it. fw_open reads 1 from the next cycle.
- R6: While the block is closed, a code-region violation (viol_seg code 1) is raised by either of two accesses: a fetch inside the code region other than the entry point, or a data access inside the code region.
- R7: A data access inside the non-volatile region is a violation (code 2) while the block is closed. It is allowed while the block is open.
- R8: While the block is closed, a data access inside the volatile region is a violation (code 3) when the share flag is 0. It is allowed when the share flag is 1.
- R9: A fetch inside the volatile region is a violation (code 3) in either state when the execute flag is 0. With the execute flag at 1, such a fetch is allowed while open, and while closed only if the share flag is 1.
- R10: While the block is open, a valid fetch outside the code region closes it, unless that fetch is inside a volatile region that allows execution. Fetches inside the code region keep the block open.
- R11: Every cycle with a violation makes rst_req 1 in the next cycle only and forces fw_open to 0. viol_seg keeps the code of the first violation after reset. When one cycle has several violations, the code region takes priority over the non-volatile region, which takes priority over the volatile region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_arm | input | 1 | Capture settings and arm (first pulse only) |
| cfg_code_start | input | ADDR_W-8 | Code region start, 256-byte units |
| cfg_code_len | input | LEN_W | Code region length, 256-byte units |
| cfg_nvd_start | input | ADDR_W-8 | Non-volatile region start, 256-byte units |
| cfg_nvd_len | input | LEN_W | Non-volatile region length, 256-byte units |
| cfg_vol_start | input | ADDR_W-6 | Volatile region start, 64-byte units |
| cfg_vol_len | input | LEN_W | Volatile region length, 64-byte units |
| cfg_vol_share | input | 1 | Volatile region usable by unprotected code |
| cfg_vol_exec | input | 1 | Execution permitted from volatile region |
| if_valid | input | 1 | Instruction fetch valid |
| if_addr | input | ADDR_W | Instruction fetch byte address |
| dat_valid | input | 1 | Data access valid |
| dat_addr | input | ADDR_W | Data access byte address |
| fw_armed | output | 1 | Settings captured and frozen |
| fw_open | output | 1 | Protected code currently entered |
| rst_req | output | 1 | One-cycle system reset request |
| viol_seg | output | 2 | First violated region: 0 none, 1 code, 2 non-volatile, 3 volatile |

## Verification
The assertions watch several invariants on every cycle. The block can only become open right after an entry-point fetch. It is never open while unarmed or in the cycle of a reset request. A reset request always comes with a recorded region. The recorded region and the frozen settings never change once set. The region boundaries, the entry-point offset, the share and execute combinations, the priority between regions and the effect of a late arm pulse cannot be shown by these invariants. Only the bench's directed scenarios can show them, checked against its behavioural model cycle by cycle.

// File: rtl/fw_pkg.sv
package fw_pkg;
   typedef enum logic [1:0] {
      SEG_NONE = 2'd0,
      SEG_CODE = 2'd1,
      SEG_NVD  = 2'd2,
      SEG_VOL  = 2'd3
   } seg_e;
endpackage

// File: rtl/fw_range.sv
module fw_range #(
   parameter int ADDR_W  = 32,
   parameter int GRAN_LG = 8,
   parameter int LEN_W   = 13,
   localparam int UW     = ADDR_W - GRAN_LG
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [UW-1:0]     start,
   input  logic [LEN_W-1:0]  len,
   output logic              hit
);
   logic [ADDR_W:0] lo_b;
   logic [ADDR_W:0] hi_b;
   logic [ADDR_W:0] a_b;

   always_comb begin
      lo_b = {1'b0, start, {GRAN_LG{1'b0}}};
      hi_b = lo_b + ((ADDR_W+1)'(len) << GRAN_LG);
      a_b  = {1'b0, addr};
      hit  = (a_b >= lo_b) && (a_b < hi_b);
   end
endmodule

// File: rtl/fw_cfg.sv
module fw_cfg #(
   parameter int CU    = 24,
   parameter int VU    = 26,
   parameter int LEN_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [CU-1:0]    code_start_i,
   input  logic [LEN_W-1:0] code_len_i,
   input  logic [CU-1:0]    nvd_start_i,
   input  logic [LEN_W-1:0] nvd_len_i,
   input  logic [VU-1:0]    vol_start_i,
   input  logic [LEN_W-1:0] vol_len_i,
   input  logic             share_i,
   input  logic             exec_i,
   output logic             armed,
   output logic [CU-1:0]    code_start,
   output logic [LEN_W-1:0] code_len,
   output logic [CU-1:0]    nvd_start,
   output logic [LEN_W-1:0] nvd_len,
   output logic [VU-1:0]    vol_start,
   output logic [LEN_W-1:0] vol_len,
   output logic             share,
   output logic             exec
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         code_start <= '0;
         code_len   <= '0;
         nvd_start  <= '0;
         nvd_len    <= '0;
         vol_start  <= '0;
         vol_len    <= '0;
         share      <= 1'b0;
         exec       <= 1'b0;
      end else if (arm && !armed) begin
         armed      <= 1'b1;
         code_start <= code_start_i;
         code_len   <= code_len_i;
         nvd_start  <= nvd_start_i;
         nvd_len    <= nvd_len_i;
         vol_start  <= vol_start_i;
         vol_len    <= vol_len_i;
         share      <= share_i;
         exec       <= exec_i;
      end
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(armed)) |-> ($stable(code_start) && $stable(code_len) && $stable(nvd_start)
         && $stable(nvd_len) && $stable(vol_start) && $stable(vol_len) && $stable(share) && $stable(exec))); // R3
endmodule

// File: rtl/fw_gate.sv
module fw_gate
   import fw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       armed,
   input  logic       share,
   input  logic       exec,
   input  logic       if_valid,
   input  logic       gate_hit,
   input  logic       f_code,
   input  logic       f_vol,
   input  logic       dat_valid,
   input  logic       d_code,
   input  logic       d_nvd,
   input  logic       d_vol,
   output logic       open,
   output logic       rst_req,
   output logic [1:0] viol_seg
);
   logic v_code, v_nvd, v_vol, v_any;
   logic open_d;
   seg_e sel, seg_q;

   always_comb begin
      v_code = armed && !open && ((if_valid && f_code && !gate_hit) || (dat_valid && d_code));
      v_nvd  = armed && !open && dat_valid && d_nvd;
      v_vol  = armed && ((if_valid && f_vol && (!exec || (!open && !share)))
                      || (!open && dat_valid && d_vol && !share));
      v_any  = v_code || v_nvd || v_vol;
      sel    = v_code ? SEG_CODE : (v_nvd ? SEG_NVD : SEG_VOL);
      open_d = open;
      if (v_any || !armed)
         open_d = 1'b0;
      else if (!open)
         open_d = if_valid && gate_hit;
      else if (if_valid && !f_code && !(f_vol && exec))
         open_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open    <= 1'b0;
         rst_req <= 1'b0;
         seg_q   <= SEG_NONE;
      end else begin
         open    <= open_d;
         rst_req <= v_any;
         if (v_any && seg_q == SEG_NONE)
            seg_q <= sel;
      end
   end

   assign viol_seg = seg_q;

   AST_OPEN_BY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open) |-> $past(if_valid && gate_hit)); // R5
   AST_OPEN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      open |-> armed); // R2
   AST_REQ_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> !open); // R11
   AST_REQ_HAS_SEG: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (viol_seg != 2'd0)); // R11
   AST_SEG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(viol_seg) != 2'd0) |-> (viol_seg == $past(viol_seg))); // R11
endmodule

// File: rtl/fw_guard.sv
module fw_guard #(
   parameter int ADDR_W   = 32,
   parameter int CODE_GLG = 8,
   parameter int VOL_GLG  = 6,
   parameter int LEN_W    = 13,
   parameter int GATE_OFS = 4,
   localparam int CU      = ADDR_W - CODE_GLG,
   localparam int VU      = ADDR_W - VOL_GLG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_arm,
   input  logic [CU-1:0]     cfg_code_start,
   input  logic [LEN_W-1:0]  cfg_code_len,
   input  logic [CU-1:0]     cfg_nvd_start,
   input  logic [LEN_W-1:0]  cfg_nvd_len,
   input  logic [VU-1:0]     cfg_vol_start,
   input  logic [LEN_W-1:0]  cfg_vol_len,
   input  logic              cfg_vol_share,
   input  logic              cfg_vol_exec,
   input  logic              if_valid,
   input  logic [ADDR_W-1:0] if_addr,
   input  logic              dat_valid,
   input  logic [ADDR_W-1:0] dat_addr,
   output logic              fw_armed,
   output logic              fw_open,
   output logic              rst_req,
   output logic [1:0]        viol_seg
);
   localparam int NPORT = 2;

   if (CODE_GLG < 3 || VOL_GLG < 3) begin : g_bad_gran
      $error("granularity too fine");
   end
   if (GATE_OFS >= (1 << CODE_GLG)) begin : g_bad_gate
      $error("entry offset beyond first code unit");
   end
   if (LEN_W > VU || LEN_W > CU) begin : g_bad_len
      $error("length field wider than address units");
   end

   logic [CU-1:0]    code_start, nvd_start;
   logic [VU-1:0]    vol_start;
   logic [LEN_W-1:0] code_len, nvd_len, vol_len;
   logic             share, exec;

   fw_cfg #(.CU(CU), .VU(VU), .LEN_W(LEN_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .arm(cfg_arm),
      .code_start_i(cfg_code_start), .code_len_i(cfg_code_len),
      .nvd_start_i(cfg_nvd_start), .nvd_len_i(cfg_nvd_len),
      .vol_start_i(cfg_vol_start), .vol_len_i(cfg_vol_len),
      .share_i(cfg_vol_share), .exec_i(cfg_vol_exec),
      .armed(fw_armed), .code_start(code_start), .code_len(code_len),
      .nvd_start(nvd_start), .nvd_len(nvd_len),
      .vol_start(vol_start), .vol_len(vol_len),
      .share(share), .exec(exec)
   );

   logic [ADDR_W-1:0] p_addr [NPORT];
   logic [NPORT-1:0]  h_code, h_nvd, h_vol;

   assign p_addr[0] = if_addr;
   assign p_addr[1] = dat_addr;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      fw_range #(.ADDR_W(ADDR_W), .GRAN_LG(CODE_GLG), .LEN_W(LEN_W)) u_code (
         .addr(p_addr[p]), .start(code_start), .len(code_len), .hit(h_code[p]));
      fw_range #(.ADDR_W(ADDR_W), .GRAN_LG(CODE_GLG), .LEN_W(LEN_W)) u_nvd (
         .addr(p_addr[p]), .start(nvd_start), .len(nvd_len), .hit(h_nvd[p]));
      fw_range #(.ADDR_W(ADDR_W), .GRAN_LG(VOL_GLG), .LEN_W(LEN_W)) u_vol (
         .addr(p_addr[p]), .start(vol_start), .len(vol_len), .hit(h_vol[p]));
   end

   logic [ADDR_W-1:0] gate_addr;
   logic              gate_hit;

   always_comb begin
      gate_addr = {code_start, {CODE_GLG{1'b0}}} + ADDR_W'(GATE_OFS);
      gate_hit  = h_code[0] && (if_addr == gate_addr);
   end

   fw_gate u_gate (
      .clk(clk), .rst_n(rst_n), .armed(fw_armed), .share(share), .exec(exec),
      .if_valid(if_valid), .gate_hit(gate_hit), .f_code(h_code[0]), .f_vol(h_vol[0]),
      .dat_valid(dat_valid), .d_code(h_code[1]), .d_nvd(h_nvd[1]), .d_vol(h_vol[1]),
      .open(fw_open), .rst_req(rst_req), .viol_seg(viol_seg)
   );
endmodule

// File: tb/fw_guard_bench.sv
module fw_guard_bench;
   localparam int AW = 32;
   localparam int LW = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_arm = 1'b0;
   logic [23:0] cfg_code_start = '0, cfg_nvd_start = '0;
   logic [25:0] cfg_vol_start = '0;
   logic [LW-1:0] cfg_code_len = '0, cfg_nvd_len = '0, cfg_vol_len = '0;
   logic cfg_vol_share = 1'b0, cfg_vol_exec = 1'b0;
   logic if_valid = 1'b0, dat_valid = 1'b0;
   logic [AW-1:0] if_addr = '0, dat_addr = '0;
   logic fw_armed, fw_open, rst_req;
   logic [1:0] viol_seg;

   int vectors = 0;
   int fails = 0;

   always #4 clk = ~clk;

   fw_guard u_fw_guard (
      .clk(clk), .rst_n(rst_n), .cfg_arm(cfg_arm),
      .cfg_code_start(cfg_code_start), .cfg_code_len(cfg_code_len),
      .cfg_nvd_start(cfg_nvd_start), .cfg_nvd_len(cfg_nvd_len),
      .cfg_vol_start(cfg_vol_start), .cfg_vol_len(cfg_vol_len),
      .cfg_vol_share(cfg_vol_share), .cfg_vol_exec(cfg_vol_exec),
      .if_valid(if_valid), .if_addr(if_addr), .dat_valid(dat_valid), .dat_addr(dat_addr),
      .fw_armed(fw_armed), .fw_open(fw_open), .rst_req(rst_req), .viol_seg(viol_seg)
   );

   // behavioural reference model
   bit m_armed, m_open, m_rst, m_sh, m_ex;
   int m_seg;
   longint m_cs, m_cl, m_ns, m_nl, m_vs, m_vl;

   function automatic bit inside_rg(longint a, longint s, longint l, longint g);
      return (a >= s * g) && (a < (s + l) * g);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_armed = 0; m_open = 0; m_rst = 0; m_seg = 0;
         m_sh = 0; m_ex = 0; m_cs = 0; m_cl = 0; m_ns = 0; m_nl = 0; m_vs = 0; m_vl = 0;
      end else begin
         bit fc, fv, dc, dn, dv, gate, vc, vn, vv, any;
         fc = inside_rg(longint'(if_addr), m_cs, m_cl, 256);
         fv = inside_rg(longint'(if_addr), m_vs, m_vl, 64);
         dc = inside_rg(longint'(dat_addr), m_cs, m_cl, 256);
         dn = inside_rg(longint'(dat_addr), m_ns, m_nl, 256);
         dv = inside_rg(longint'(dat_addr), m_vs, m_vl, 64);
         gate = fc && (longint'(if_addr) == m_cs * 256 + 4);
         vc = m_armed && !m_open && ((if_valid && fc && !gate) || (dat_valid && dc));
         vn = m_armed && !m_open && dat_valid && dn;
         vv = m_armed && ((if_valid && fv && (!m_ex || (!m_open && !m_sh)))
                          || (!m_open && dat_valid && dv && !m_sh));
         any = vc || vn || vv;
         m_rst = any;
         if (any && m_seg == 0) m_seg = vc ? 1 : (vn ? 2 : 3);
         if (any || !m_armed) m_open = 0;
         else if (!m_open) m_open = if_valid && gate;
         else if (if_valid && !fc && !(fv && m_ex)) m_open = 0;
         if (cfg_arm && !m_armed) begin
            m_armed = 1;
            m_cs = longint'(cfg_code_start); m_cl = longint'(cfg_code_len);
            m_ns = longint'(cfg_nvd_start);  m_nl = longint'(cfg_nvd_len);
            m_vs = longint'(cfg_vol_start);  m_vl = longint'(cfg_vol_len);
            m_sh = cfg_vol_share; m_ex = cfg_vol_exec;
         end
      end
   end

   always @(negedge clk) begin
      vectors++;
      if (fw_armed !== m_armed) begin
         fails++; $display("FAIL R2,R3 fw_armed act=%0d exp=%0d", fw_armed, m_armed);
      end
      if (fw_open !== m_open) begin
         fails++; $display("FAIL R5,R10 fw_open act=%0d exp=%0d", fw_open, m_open);
      end
      if (rst_req !== m_rst) begin
         fails++; $display("FAIL R11 rst_req act=%0d exp=%0d", rst_req, m_rst);
      end
      if (int'(viol_seg) != m_seg || $isunknown(viol_seg)) begin
         fails++; $display("FAIL R11 viol_seg act=%0d exp=%0d", viol_seg, m_seg);
      end
   end

   task automatic chk(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(bit iv, logic [AW-1:0] ia, bit dv, logic [AW-1:0] da);
      if_valid = iv; if_addr = ia; dat_valid = dv; dat_addr = da;
      @(negedge clk);
      if_valid = 0; dat_valid = 0;
   endtask

   task automatic idle();
      cyc(0, '0, 0, '0);
   endtask

   task automatic do_reset();
      rst_n = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1;
   endtask

   task automatic arm(bit sh, bit ex);
      cfg_code_start = 24'h10; cfg_code_len = 13'd4;   // 0x1000..0x13FF
      cfg_nvd_start  = 24'h20; cfg_nvd_len  = 13'd2;   // 0x2000..0x21FF
      cfg_vol_start  = 26'h100; cfg_vol_len = 13'd8;   // 0x4000..0x41FF
      cfg_vol_share = sh; cfg_vol_exec = ex;
      cfg_arm = 1;
      @(negedge clk);
      cfg_arm = 0;
   endtask

   initial begin
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 open in reset", int'(fw_open), 0);
      chk("R1 req in reset", int'(rst_req), 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 armed after reset", int'(fw_armed), 0);
      chk("R1 seg after reset", int'(viol_seg), 0);

      cyc(1, 32'h1008, 1, 32'h2000);
      chk("R2 unarmed no request", int'(rst_req), 0);
      arm(0, 0);
      chk("R2 armed", int'(fw_armed), 1);

      cfg_nvd_start = 24'h30; cfg_arm = 1;
      @(negedge clk);
      cfg_arm = 0;
      cyc(0, '0, 1, 32'h3000);
      chk("R3 late settings ignored", int'(rst_req), 0);
      cyc(0, '0, 1, 32'h2010);
      chk("R3 original nvd kept", int'(viol_seg), 2);
      chk("R7 closed nvd request", int'(rst_req), 1);
      idle();
      chk("R11 single pulse", int'(rst_req), 0);

      do_reset(); arm(0, 0);
      cyc(0, '0, 1, 32'h2200);
      chk("R4 past nvd end", int'(rst_req), 0);
      cyc(0, '0, 1, 32'h0FFF);
      chk("R4 below code start", int'(rst_req), 0);
      cyc(1, 32'h1004, 0, '0);
      chk("R5 entry opens", int'(fw_open), 1);
      cyc(1, 32'h1100, 1, 32'h21FF);
      chk("R7 open nvd allowed", int'(rst_req), 0);
      cyc(1, 32'h13FC, 0, '0);
      chk("R10 stays open in code", int'(fw_open), 1);
      cyc(1, 32'h1400, 0, '0);
      chk("R10 leaving closes", int'(fw_open), 0);
      cyc(1, 32'h1008, 0, '0);
      chk("R6 closed code fetch", int'(viol_seg), 1);
      idle();
      chk("R11 pulse ends", int'(rst_req), 0);

      do_reset(); arm(0, 0);
      cyc(0, '0, 1, 32'h1200);
      chk("R6 closed code data", int'(viol_seg), 1);

      do_reset(); arm(0, 0);
      cyc(0, '0, 1, 32'h4000);
      chk("R8 unshared vol data", int'(viol_seg), 3);

      do_reset(); arm(1, 0);
      cyc(0, '0, 1, 32'h41FF);
      chk("R8 shared vol data", int'(rst_req), 0);
      cyc(1, 32'h1004, 0, '0);
      cyc(1, 32'h4040, 0, '0);
      chk("R9 no exec vol fetch", int'(viol_seg), 3);
      chk("R11 violation closes", int'(fw_open), 0);

      do_reset(); arm(1, 1);
      cyc(1, 32'h4000, 0, '0);
      chk("R9 shared exec closed fetch", int'(rst_req), 0);
      cyc(1, 32'h1004, 0, '0);
      cyc(1, 32'h4100, 0, '0);
      chk("R10 exec vol keeps open", int'(fw_open), 1);
      cyc(1, 32'h8000, 0, '0);
      chk("R10 outside closes", int'(fw_open), 0);

      do_reset(); arm(0, 1);
      cyc(1, 32'h4000, 0, '0);
      chk("R9 unshared closed fetch", int'(viol_seg), 3);

      do_reset(); arm(0, 0);
      cyc(1, 32'h1008, 1, 32'h4000);
      chk("R11 priority code", int'(viol_seg), 1);
      cyc(0, '0, 1, 32'h2000);
      chk("R11 request again", int'(rst_req), 1);
      chk("R11 seg sticky", int'(viol_seg), 1);
      idle();

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule